// File: doc/BRIEF.md
# DMA Window Address Decoder

This block sits on the inbound DMA path of a PCI host bridge. It turns an address that a PCI device puts on the bus into a system memory address. Software sets up four address windows and a control register through a plain register write/read port. Each window has a base register, a mask register and a translated-base register. For every translation request the block compares the address against the windows. It then reports one of four outcomes: a direct-mapped system address, a scatter-gather request carrying the page-table-entry address that a separate lookup engine should fetch, a 64-bit pass-through, or a fault.

Single-cycle (32-bit) addresses go through the windows in a fixed priority. A control bit can reserve a small low-memory range so that it never matches any window. 64-bit addresses are served in two ways. One is a fixed pass-through range that keeps the low 35 address bits. The other is a scatter-gather path through window 3, enabled by a dual-address-cycle bit at bit 39 of that window's base register. The result comes out one clock after the request, as a single-cycle valid pulse with an outcome code.

Top module: `dma_window_decoder`

## Requirements
- R1: After reset, every base, mask and translated-base register reads 0, except window 3's base register, which reads 2. The control register reads 0, and `xlat_valid` is low.
- R2: Window n (0 to 3) has its base register at offset 0x40·n, its mask register at 0x100 + 0x40·n and its translated-base register at 0x200 + 0x40·n. The control register is at 0x300. Reads are combinational and return the stored value. Any other offset reads 0.
- R3: A write stores only bits 31:20 and 1:0 in base registers 0 to 2 (mask 0xFFF00003), only bits 31:20 in mask registers (0xFFF00000), and only bits 34:10 in translated-base registers (0x7FFFFFC00).
- R4: A write to window 3's base register stores bits 39, 31:20 and 0 (mask 0x80FFF00001), and bit 1 always reads 1.
- R5: A control write changes only the bits under 0x1CFF0FC7FF. All other control bits keep their stored value, which reads back unchanged.
- R6: Base bit 0 enables a window. An enabled window hits when (addr & ~(mask | 0xFFFFF)) equals (base & 0xFFF00000). A single-cycle address that hits no usable window faults.
- R7: For an address at or below 0xFFFFFFFF, windows 0, 1 and 2 are tried in ascending order and the lowest hit wins. Window 3 is tried last, and only while its base bit 39 is 0.
- R8: When the winning window has base bit 1 clear, the outcome is direct (code 1) with output (tba & ~ext) | (addr & ext), where ext = mask | 0xFFFFF.
- R9: When the winning window has base bit 1 set, the outcome is scatter-gather (code 2). The output is the entry address (tba & ~(mask >> 10)) | ((addr & (mask | 0xFE000)) >> 10).
- R10: While control bit 5 is 1, every single-cycle address from 0x80000 to 0xFFFFF faults, whatever the windows hold.
- R11: While control bit 6 is 1, an address from 0x10000000000 to 0x1FFFFFFFFFF passes through (code 3) with output addr & 0x7FFFFFFFF.
- R12: An address from 0x80000000000 to 0xFFFFFFFFFFF gives scatter-gather (code 2) when window 3 has base bits 39 and 0 both set. The output is (tba3 & 0x7FFC00000) | ((addr & 0xFFFFE000) >> 10). Any other 64-bit address faults.
- R13: `xlat_valid` is high for exactly the cycle after each request and low otherwise. A fault carries code 0 and output 0. A register write in the same cycle as a request does not affect that request's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| xlat_req | input | 1 | Translation request |
| xlat_addr | input | 64 | PCI-side DMA address |
| xlat_valid | output | 1 | Result strobe, one cycle after the request |
| xlat_kind | output | 2 | 0 fault, 1 direct, 2 scatter-gather, 3 pass-through |
| xlat_out | output | 64 | System address or page-table-entry address |

## Verification
The hardest case to reach is overlapping windows that resolve by priority. An address must match two or three enabled windows at once, or match window 3 while its dual-address-cycle bit blocks it. To set this up, the stimulus programs windows 0 and 1 over the same megabyte, disables window 0, and then toggles bit 39 of window 3 while the same address is presented. A random phase then mixes writes to the real offsets with addresses drawn near the window bases, the reserved low range and both 64-bit ranges. The behavioural model checks every result and every read-back.

// File: rtl/dma_window_decoder.sv
module dma_window_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [9:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        xlat_req,
  input  logic [63:0] xlat_addr,
  output logic        xlat_valid,
  output logic [1:0]  xlat_kind,
  output logic [63:0] xlat_out
);
  localparam int          NWIN       = 4;
  localparam int          DAC_BIT    = 39;
  localparam logic [63:0] BASE_KEEP  = 64'h0000_0000_FFF0_0003;
  localparam logic [63:0] BASE3_KEEP = 64'h0000_0080_FFF0_0001;
  localparam logic [63:0] MASK_KEEP  = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] TBA_KEEP   = 64'h0000_0007_FFFF_FC00;
  localparam logic [63:0] CTL_KEEP   = 64'h0000_1CFF_0FC7_FF;
  localparam logic [63:0] LOW_EXT    = 64'h0000_0000_000F_FFFF;
  localparam logic [1:0]  K_FAULT = 2'd0, K_DIRECT = 2'd1, K_SG = 2'd2, K_PASS = 2'd3;

  logic [63:0] base_q [NWIN];
  logic [63:0] mask_q [NWIN];
  logic [63:0] tba_q  [NWIN];
  logic [63:0] ctl_q;
  logic [63:0] ext [NWIN];
  logic [63:0] direct_a [NWIN];
  logic [63:0] pte_a [NWIN];
  logic [NWIN-1:0] hit, usable;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign ext[i]      = mask_q[i] | LOW_EXT;
    assign hit[i]      = base_q[i][0] && ((xlat_addr & ~ext[i]) == (base_q[i] & MASK_KEEP));
    assign direct_a[i] = (tba_q[i] & ~ext[i]) | (xlat_addr & ext[i]);
    assign pte_a[i]    = (tba_q[i] & ~(mask_q[i] >> 10))
                       | ((xlat_addr & (mask_q[i] | 64'hF_E000)) >> 10);
  end
  assign usable = hit & {~base_q[NWIN-1][DAC_BIT], {(NWIN-1){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= (i == NWIN-1) ? 64'd2 : 64'd0;
        mask_q[i] <= '0;
        tba_q[i]  <= '0;
      end
      ctl_q <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NWIN; i++) begin
        if (reg_addr == 10'(i*64))
          base_q[i] <= (i == NWIN-1) ? ((reg_wdata & BASE3_KEEP) | 64'd2) : (reg_wdata & BASE_KEEP);
        if (reg_addr == 10'(256 + i*64)) mask_q[i] <= reg_wdata & MASK_KEEP;
        if (reg_addr == 10'(512 + i*64)) tba_q[i]  <= reg_wdata & TBA_KEEP;
      end
      if (reg_addr == 10'h300) ctl_q <= (ctl_q & ~CTL_KEEP) | (reg_wdata & CTL_KEEP);
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (reg_addr == 10'(i*64))       reg_rdata = base_q[i];
      if (reg_addr == 10'(256 + i*64)) reg_rdata = mask_q[i];
      if (reg_addr == 10'(512 + i*64)) reg_rdata = tba_q[i];
    end
    if (reg_addr == 10'h300) reg_rdata = ctl_q;
  end

  logic        sac, hole, pass_rng, dac_rng;
  logic [1:0]  kind_d;
  logic [63:0] out_d;

  assign sac      = xlat_addr[63:32] == 32'd0;
  assign hole     = ctl_q[5] && xlat_addr >= 64'h8_0000 && xlat_addr <= 64'hF_FFFF;
  assign pass_rng = xlat_addr >= 64'h100_0000_0000 && xlat_addr <= 64'h1FF_FFFF_FFFF;
  assign dac_rng  = xlat_addr >= 64'h800_0000_0000 && xlat_addr <= 64'hFFF_FFFF_FFFF;

  always_comb begin
    kind_d = K_FAULT;
    out_d  = '0;
    if (sac) begin
      if (!hole)
        for (int i = NWIN-1; i >= 0; i--)
          if (usable[i]) begin
            kind_d = base_q[i][1] ? K_SG : K_DIRECT;
            out_d  = base_q[i][1] ? pte_a[i] : direct_a[i];
          end
    end else if (ctl_q[6] && pass_rng) begin
      kind_d = K_PASS;
      out_d  = xlat_addr & 64'h7_FFFF_FFFF;
    end else if (dac_rng && base_q[NWIN-1][DAC_BIT] && base_q[NWIN-1][0]) begin
      kind_d = K_SG;
      out_d  = (tba_q[NWIN-1] & 64'h7_FFC0_0000) | ((xlat_addr & 64'hFFFF_E000) >> 10);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_valid <= 1'b0;
      xlat_kind  <= K_FAULT;
      xlat_out   <= '0;
    end else begin
      xlat_valid <= xlat_req;
      xlat_kind  <= xlat_req ? kind_d : K_FAULT;
      xlat_out   <= xlat_req ? out_d : '0;
    end
  end
endmodule

// File: rtl/dma_window_decoder_chk.sv
module dma_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  reg_addr,
  input logic [63:0] reg_rdata,
  input logic        xlat_req,
  input logic [63:0] xlat_addr,
  input logic        xlat_valid,
  input logic [1:0]  xlat_kind,
  input logic [63:0] xlat_out,
  input logic [63:0] ctl_q
);
  logic known_off;
  assign known_off = (reg_addr == 10'h300) || (reg_addr[5:0] == 6'd0 && reg_addr < 10'h300);

  a_r13_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |=> xlat_valid);

  a_r13_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_req |=> !xlat_valid);

  a_r13_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid && xlat_kind == 2'd0) |-> xlat_out == 64'd0);

  a_r10_hole_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && ctl_q[5] && xlat_addr >= 64'h8_0000 && xlat_addr <= 64'hF_FFFF) |=> xlat_kind == 2'd0);

  a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req && ctl_q[6] && xlat_addr >= 64'h100_0000_0000 && xlat_addr <= 64'h1FF_FFFF_FFFF)
    |=> (xlat_kind == 2'd3 && xlat_out == ($past(xlat_addr) & 64'h7_FFFF_FFFF)));

  a_r2_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !known_off |-> reg_rdata == 64'd0);

  a_r4_sg_bit_forced: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 10'h0C0 |-> reg_rdata[1]);
endmodule

bind dma_window_decoder dma_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .xlat_req(xlat_req), .xlat_addr(xlat_addr), .xlat_valid(xlat_valid),
  .xlat_kind(xlat_kind), .xlat_out(xlat_out), .ctl_q(ctl_q)
);

// File: tb/tb_dma_window_decoder.sv
module tb_dma_window_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [9:0]  reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic        xlat_req = 0;
  logic [63:0] xlat_addr = 0;
  logic        xlat_valid;
  logic [1:0]  xlat_kind;
  logic [63:0] xlat_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_window_decoder dut (.*);

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_tba  [4];
  logic [63:0] m_ctl;
  logic        e_valid;
  logic [1:0]  e_kind;
  logic [63:0] e_out;
  string       e_tag = "R1";

  function automatic logic [63:0] m_read(input logic [9:0] a);
    int w = a / 64;
    if (a == 10'h300) return m_ctl;
    if (a % 64 != 0 || a > 10'h2C0) return 64'd0;
    if (w < 4) return m_base[w];
    if (w < 8) return m_mask[w-4];
    return m_tba[w-8];
  endfunction

  function automatic void m_xlat(input logic [63:0] a, output logic [1:0] k,
                                 output logic [63:0] o, output string t);
    logic [63:0] e;
    int first = -1;
    int nhit = 0;
    k = 0; o = 0; t = "R6";
    if (a <= 64'hFFFF_FFFF) begin
      if (m_ctl[5] && a >= 64'h80000 && a <= 64'hFFFFF) begin t = "R10"; return; end
      for (int w = 0; w < 4; w++) begin
        e = m_mask[w] | 64'hFFFFF;
        if (m_base[w][0] && ((a & ~e) == (m_base[w] & 64'hFFF00000))) begin
          nhit++;
          if (first < 0 && !(w == 3 && m_base[3][39])) first = w;
        end
      end
      if (first < 0) begin t = (nhit > 0) ? "R7" : "R6"; return; end
      e = m_mask[first] | 64'hFFFFF;
      if (m_base[first][1]) begin
        k = 2; t = "R9";
        o = (m_tba[first] & ~(m_mask[first] >> 10)) | ((a & (m_mask[first] | 64'hFE000)) >> 10);
      end else begin
        k = 1; t = "R8";
        o = (m_tba[first] & ~e) | (a & e);
      end
      if (nhit > 1) t = "R7";
    end else if (m_ctl[6] && a >= 64'h100_0000_0000 && a <= 64'h1FF_FFFF_FFFF) begin
      k = 3; o = a & 64'h7_FFFF_FFFF; t = "R11";
    end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && m_base[3][39] && m_base[3][0]) begin
      k = 2; t = "R12";
      o = (m_tba[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 4; w++) begin
        m_base[w] = (w == 3) ? 64'd2 : 64'd0;
        m_mask[w] = 0;
        m_tba[w] = 0;
      end
      m_ctl = 0; e_valid = 0; e_kind = 0; e_out = 0; e_tag = "R1";
    end else begin
      e_valid = xlat_req;
      if (xlat_req) m_xlat(xlat_addr, e_kind, e_out, e_tag);
      else begin e_kind = 0; e_out = 0; e_tag = "R13"; end
      if (reg_wr) begin
        for (int w = 0; w < 4; w++) begin
          if (reg_addr == 10'(w*64))
            m_base[w] = (w == 3) ? ((reg_wdata & 64'h80FFF00001) | 64'd2) : (reg_wdata & 64'hFFF00003);
          if (reg_addr == 10'(256 + w*64)) m_mask[w] = reg_wdata & 64'hFFF00000;
          if (reg_addr == 10'(512 + w*64)) m_tba[w] = reg_wdata & 64'h7FFFFFC00;
        end
        if (reg_addr == 10'h300)
          m_ctl = (m_ctl & ~64'h1CFF0FC7FF) | (reg_wdata & 64'h1CFF0FC7FF);
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2", "reg_rdata", reg_rdata, m_read(reg_addr));
      check(e_tag, "valid/kind/out", {xlat_valid, xlat_kind, xlat_out[60:0]},
            {e_valid, e_kind, e_out[60:0]});
      check(e_tag, "out high bits", {61'd0, xlat_out[63:61]}, {61'd0, e_out[63:61]});
    end
  end

  task automatic cyc(input bit wr, input logic [9:0] a, input logic [63:0] d,
                     input bit req, input logic [63:0] xa);
    @(negedge clk); #1;
    reg_wr = wr; reg_addr = a; reg_wdata = d; xlat_req = req; xlat_addr = xa;
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  task automatic rd(input logic [9:0] a, input logic [63:0] exp, input string tag);
    cyc(0, a, 0, 0, 0);
    #2 check(tag, "read", reg_rdata, exp);
  endtask

  task automatic req(input logic [63:0] xa);
    cyc(0, 10'h3FF, 0, 1, xa);
  endtask

  function automatic logic [63:0] pick_addr(input int sel);
    case (sel % 8)
      0: return {32'd0, $urandom};
      1: return 64'h4000_0000 + 64'($urandom % 32'h0200_0000);
      2: return 64'h8_0000 + 64'($urandom % 32'h9_0000) - 64'h1_0000;
      3: return 64'h8000_0000 + 64'($urandom % 32'h0020_0000);
      4: return 64'h100_0000_0000 + {32'd0, $urandom} * 64'h100;
      5: return 64'h800_0000_0000 + {32'd0, $urandom} * 64'h100;
      6: return {$urandom, $urandom};
      default: return 64'h4000_0000 + 64'($urandom % 32'h0010_0000);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1: reset values
    for (int w = 0; w < 4; w++) begin
      rd(10'(w*64), (w == 3) ? 64'd2 : 64'd0, "R1");
      rd(10'(256 + w*64), 64'd0, "R1");
      rd(10'(512 + w*64), 64'd0, "R1");
    end
    rd(10'h300, 64'd0, "R1");
    check("R1", "valid after reset", {63'd0, xlat_valid}, 64'd0);
    // R3, R4, R5, R2: write masks and map
    wr(10'h000, '1); rd(10'h000, 64'hFFF00003, "R3");
    wr(10'h140, '1); rd(10'h140, 64'hFFF00000, "R3");
    wr(10'h280, '1); rd(10'h280, 64'h7FFFFFC00, "R3");
    wr(10'h0C0, '1); rd(10'h0C0, 64'h80FFF00003, "R4");
    wr(10'h0C0, 64'd0); rd(10'h0C0, 64'd2, "R4");
    wr(10'h300, '1); rd(10'h300, 64'h1CFF0FC7FF, "R5");
    wr(10'h300, 64'd0); rd(10'h300, 64'd0, "R5");
    rd(10'h008, 64'd0, "R2"); rd(10'h340, 64'd0, "R2"); rd(10'h3C0, 64'd0, "R2");
    // windows: 0 direct, 1 scatter-gather overlapping, 3 scatter-gather
    wr(10'h000, 64'h4000_0001); wr(10'h100, 64'h0FF0_0000); wr(10'h200, 64'h1_2000_0000);
    wr(10'h040, 64'h4000_0003); wr(10'h140, 64'h0);         wr(10'h240, 64'h0_3000_0400);
    wr(10'h280, 64'h0);
    wr(10'h0C0, 64'h8000_0001); wr(10'h1C0, 64'h0);         wr(10'h2C0, 64'h1000_0000);
    req(64'h4123_4567); req(64'h4000_1234);
    wr(10'h000, 64'h4000_0000);
    req(64'h4000_1234); req(64'h4010_0000);
    req(64'h8001_2000);
    wr(10'h0C0, 64'h80_8000_0001);
    req(64'h8001_2000); req(64'h800_1234_5000); req(64'hFFF_FFFF_FFFF); req(64'h1000_0000_0000);
    wr(10'h080, 64'h0000_0001);
    req(64'h9_0000); req(64'h7_FFFF);
    wr(10'h300, 64'h20);
    req(64'h9_0000); req(64'h8_0000); req(64'hF_FFFF); req(64'h7_FFFF); req(64'h10_0000);
    req(64'h100_0000_0000);
    wr(10'h300, 64'h40);
    req(64'h100_0000_0000); req(64'h1AB_CDEF_0123); req(64'h1FF_FFFF_FFFF); req(64'h200_0000_0000);
    // same-cycle write and request
    cyc(1, 10'h300, 64'h0, 1, 64'h1AB_CDEF_0123);
    req(64'h1AB_CDEF_0123);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      if (r < 12) begin
        logic [9:0] off = (r % 2 == 0) ? 10'h300 : 10'(($urandom % 12) * 64);
        logic [63:0] d = {$urandom, $urandom};
        if (off < 10'h100) d = (d & 64'h80_FFF0_0003) | 64'h4000_0000 * ($urandom % 3);
        if (off >= 10'h100 && off < 10'h200) d = d & 64'h0FFF_FFFF;
        cyc(1, off, d, 0, 0);
      end else if (r < 20) begin
        cyc(0, 10'($urandom), 0, 0, 0);
      end else begin
        cyc((r % 7) == 0, 10'h300, {$urandom, $urandom}, 1, pick_addr(r));
      end
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule